// File: doc/BRIEF.md
# Control-Law Region Mapper with Transient Frequency Floor

This block turns a digitized control-law code from a primary-side regulated flyback loop into two commands for the power stage: a peak-current fraction and a switching-frequency demand. The code range is cut into four steady-state regions plus a constant-current region. In the light region, peak current is pinned at a quarter of maximum and frequency rises with the code. In the medium region, frequency is pinned at an amplitude-modulation value and peak current rises with the code. In the heavy region, peak current is at maximum and frequency climbs toward the ceiling. Codes above the top threshold flag constant-current operation.

The block also keeps a minimum-frequency floor. The floor starts low. It arms at the high value once the demand climbs past it. After a load drop pulls the demand under the floor, the high floor is held so that the next load step-up is served quickly. The hold ends on an output overshoot sample or after a run of millisecond ticks with the output above regulation. The frequency command is the larger of the region demand and the active floor.

Top module: `flyback_law_map`

## Requirements
- R1: While rst_ni is low, the outputs read as follows: peak_o = 0, freq_o = 0, cc_o = 0, region_o = 0, and floor_o = F_LO (default 1000).
- R2: Region codes on region_o are 0 standby (code < THR_A), 1 light (THR_A ≤ code < THR_B), 2 medium (THR_B ≤ code < THR_C), 3 heavy (THR_C ≤ code ≤ THR_CC) and 4 constant-current (code > THR_CC). The defaults are THR_A=200, THR_B=400, THR_C=600 and THR_CC=980.
- R3: In standby, peak_o is the quarter value PK_MAX/4 (63 with the 8-bit default, where PK_MAX=255) and the demand is F_LO.
- R4: In light, peak_o is the quarter value and the demand is F_LO + (code−THR_A)·(F_AM−F_LO)/(THR_B−THR_A), truncated, with F_AM=25000.
- R5: In medium, the demand is F_AM and peak_o is PK_MAX/4 + (code−THR_B)·(PK_MAX−PK_MAX/4)/(THR_C−THR_B), truncated.
- R6: In heavy, peak_o = PK_MAX and the demand is F_AM + (code−THR_C)·(F_MAX−F_AM)/(THR_CC−THR_C), truncated, with F_MAX=85000.
- R7: Above THR_CC, cc_o = 1, peak_o = PK_MAX and the demand is F_MAX. cc_o is 0 at code THR_CC.
- R8: freq_o is the larger of the demand and the floor in force. All outputs are registered one clock after the code.
- R9: The floor has three states: low (F_LO, the reset state), armed (F_FLOOR=4000) and hold (F_FLOOR). Low or hold moves to armed only when the demand is strictly above F_FLOOR. A demand equal to F_FLOOR does not arm the floor, and leaving hold this way clears the hold count.
- R10: In armed, a demand strictly below F_FLOOR enters hold, and freq_o stays at F_FLOOR.
- R11: In hold, a sample strobe with vo_above_ovs_i = 1 releases the floor to low at once.
- R12: In hold, the floor releases to low on the HOLD_MS-th (default 500) ms_tick_i counted. A tick is counted only while the latest output sample was above regulation.
- R13: In hold, a sample with vo_above_reg_i = 0 clears the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cl_code_i | input | CL_W (10) | Digitized control-law code |
| sample_valid_i | input | 1 | Per-switching-cycle output sample strobe |
| vo_above_reg_i | input | 1 | Sample is above the regulation level |
| vo_above_ovs_i | input | 1 | Sample is above regulation plus 10% |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| peak_o | output | PK_W (8) | Peak-current fraction, PK_MAX = full |
| freq_o | output | FQ_W (17) | Switching-frequency command in Hz |
| cc_o | output | 1 | Constant-current mode flag |
| region_o | output | 3 | Active region code |
| floor_o | output | FQ_W (17) | Active minimum-frequency floor in Hz |

## Verification
The bench probes every region edge: the last light code against the first medium code, the last medium code against the first heavy code, and the code at THR_CC against the one above it. An off-by-one compare shows up there as a wrong region number or a peak value that jumps a step early. A demand exactly equal to the floor must leave the floor low. A design with a non-strict compare would arm the floor and hold 4 kHz after the next small drop. The hold timeout is driven with 499 ticks and then one more. The bench also sends ticks while the latest sample was below regulation, and it sends a below sample part-way through a count. A design that counts blind, or that never clears the count, would release the floor early. Finally, the demand is raised back above the floor during a hold and then dropped again. A design that keeps the stale count would release early after that second drop.

// File: rtl/flyback_law_pkg.sv
package flyback_law_pkg;
  typedef enum logic [2:0] {
    RG_STANDBY = 3'd0,
    RG_LIGHT   = 3'd1,
    RG_MEDIUM  = 3'd2,
    RG_HEAVY   = 3'd3,
    RG_CC      = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    FL_LOW   = 2'd0,
    FL_ARMED = 2'd1,
    FL_HOLD  = 2'd2
  } floor_st_e;
endpackage

// File: rtl/cl_region_map.sv
module cl_region_map
  import flyback_law_pkg::*;
#(
  parameter int CL_W    = 10,
  parameter int PK_W    = 8,
  parameter int FQ_W    = 17,
  parameter int THR_A   = 200,
  parameter int THR_B   = 400,
  parameter int THR_C   = 600,
  parameter int THR_CC  = 980,
  parameter int F_LO    = 1000,
  parameter int F_AM    = 25000,
  parameter int F_MAX   = 85000
) (
  input  logic [CL_W-1:0] code_i,
  output region_e         region_o,
  output logic [PK_W-1:0] peak_o,
  output logic [FQ_W-1:0] demand_o
);
  localparam int PW     = CL_W + FQ_W + 1;
  localparam int PK_MAX = (1 << PK_W) - 1;
  localparam int PK_QTR = PK_MAX / 4;

  localparam logic [CL_W-1:0] T_A  = CL_W'(THR_A);
  localparam logic [CL_W-1:0] T_B  = CL_W'(THR_B);
  localparam logic [CL_W-1:0] T_C  = CL_W'(THR_C);
  localparam logic [CL_W-1:0] T_CC = CL_W'(THR_CC);

  // linear interpolation between lo and hi across span codes
  function automatic logic [PW-1:0] lerp(input logic [PW-1:0] lo, input logic [PW-1:0] hi,
                                         input logic [PW-1:0] off, input logic [PW-1:0] span);
    lerp = lo + (off * (hi - lo)) / span;
  endfunction

  logic [PW-1:0] code_w;
  assign code_w = PW'(code_i);

  always_comb begin
    region_o = RG_STANDBY;
    peak_o   = PK_W'(PK_QTR);
    demand_o = FQ_W'(F_LO);
    if (code_i > T_CC) begin
      region_o = RG_CC;
      peak_o   = PK_W'(PK_MAX);
      demand_o = FQ_W'(F_MAX);
    end else if (code_i >= T_C) begin
      region_o = RG_HEAVY;
      peak_o   = PK_W'(PK_MAX);
      demand_o = FQ_W'(lerp(PW'(F_AM), PW'(F_MAX), code_w - PW'(THR_C), PW'(THR_CC - THR_C)));
    end else if (code_i >= T_B) begin
      region_o = RG_MEDIUM;
      peak_o   = PK_W'(lerp(PW'(PK_QTR), PW'(PK_MAX), code_w - PW'(THR_B), PW'(THR_C - THR_B)));
      demand_o = FQ_W'(F_AM);
    end else if (code_i >= T_A) begin
      region_o = RG_LIGHT;
      demand_o = FQ_W'(lerp(PW'(F_LO), PW'(F_AM), code_w - PW'(THR_A), PW'(THR_B - THR_A)));
    end
  end
endmodule

// File: rtl/freq_floor_ctrl.sv
module freq_floor_ctrl
  import flyback_law_pkg::*;
#(
  parameter int FQ_W    = 17,
  parameter int F_LO    = 1000,
  parameter int F_FLOOR = 4000,
  parameter int HOLD_MS = 500
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FQ_W-1:0] demand_i,
  input  logic            sample_valid_i,
  input  logic            above_reg_i,
  input  logic            above_ovs_i,
  input  logic            ms_tick_i,
  output logic [FQ_W-1:0] floor_o
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [FQ_W-1:0] FLR = FQ_W'(F_FLOOR);
  localparam logic [CW-1:0]   CNT_LAST = CW'(HOLD_MS - 1);

  floor_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          above_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             above_q <= 1'b0;
    else if (sample_valid_i) above_q <= above_reg_i;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      FL_LOW: begin
        if (demand_i > FLR) st_d = FL_ARMED;
      end
      FL_ARMED: begin
        if (demand_i < FLR) begin
          st_d  = FL_HOLD;
          cnt_d = '0;
        end
      end
      FL_HOLD: begin
        if (demand_i > FLR) begin
          st_d  = FL_ARMED;
          cnt_d = '0;
        end else if (sample_valid_i && above_ovs_i) begin
          st_d  = FL_LOW;
          cnt_d = '0;
        end else if (sample_valid_i && !above_reg_i) begin
          cnt_d = '0;
        end else if (ms_tick_i && above_q) begin
          if (cnt_q == CNT_LAST) begin
            st_d  = FL_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = FL_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FL_LOW;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign floor_o = (st_q == FL_LOW) ? FQ_W'(F_LO) : FLR;

  assert_ovs_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FL_HOLD && demand_i <= FLR && sample_valid_i && above_ovs_i) |=> st_q == FL_LOW);

  assert_below_clears_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FL_HOLD && sample_valid_i && !above_reg_i) |=> cnt_q == '0);

  assert_cnt_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HOLD_MS));

  assert_no_weak_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FL_LOW && demand_i <= FLR) |=> st_q == FL_LOW);

  assert_drop_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FL_ARMED && demand_i < FLR) |=> st_q == FL_HOLD);
endmodule

// File: rtl/flyback_law_map.sv
module flyback_law_map
  import flyback_law_pkg::*;
#(
  parameter int CL_W    = 10,
  parameter int PK_W    = 8,
  parameter int FQ_W    = 17,
  parameter int THR_A   = 200,
  parameter int THR_B   = 400,
  parameter int THR_C   = 600,
  parameter int THR_CC  = 980,
  parameter int F_LO    = 1000,
  parameter int F_FLOOR = 4000,
  parameter int F_AM    = 25000,
  parameter int F_MAX   = 85000,
  parameter int HOLD_MS = 500
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CL_W-1:0] cl_code_i,
  input  logic            sample_valid_i,
  input  logic            vo_above_reg_i,
  input  logic            vo_above_ovs_i,
  input  logic            ms_tick_i,
  output logic [PK_W-1:0] peak_o,
  output logic [FQ_W-1:0] freq_o,
  output logic            cc_o,
  output logic [2:0]      region_o,
  output logic [FQ_W-1:0] floor_o
);
  localparam int PK_MAX = (1 << PK_W) - 1;
  localparam int PK_QTR = PK_MAX / 4;

  region_e         region_c, region_q;
  logic [PK_W-1:0] peak_c, peak_q;
  logic [FQ_W-1:0] demand_c, floor_c, freq_q;

  cl_region_map #(
    .CL_W(CL_W), .PK_W(PK_W), .FQ_W(FQ_W),
    .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C), .THR_CC(THR_CC),
    .F_LO(F_LO), .F_AM(F_AM), .F_MAX(F_MAX)
  ) i_map (
    .code_i   (cl_code_i),
    .region_o (region_c),
    .peak_o   (peak_c),
    .demand_o (demand_c)
  );

  freq_floor_ctrl #(
    .FQ_W(FQ_W), .F_LO(F_LO), .F_FLOOR(F_FLOOR), .HOLD_MS(HOLD_MS)
  ) i_floor (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .demand_i       (demand_c),
    .sample_valid_i (sample_valid_i),
    .above_reg_i    (vo_above_reg_i),
    .above_ovs_i    (vo_above_ovs_i),
    .ms_tick_i      (ms_tick_i),
    .floor_o        (floor_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= RG_STANDBY;
      peak_q   <= '0;
      freq_q   <= '0;
    end else begin
      region_q <= region_c;
      peak_q   <= peak_c;
      freq_q   <= (demand_c > floor_c) ? demand_c : floor_c;
    end
  end

  assign peak_o   = peak_q;
  assign freq_o   = freq_q;
  assign region_o = region_q;
  assign cc_o     = (region_q == RG_CC);
  assign floor_o  = floor_c;

  assert_cc_peak_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_o |-> peak_o == PK_W'(PK_MAX));

  assert_light_peak_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 3'd1) |-> peak_o == PK_W'(PK_QTR));

  assert_heavy_peak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 3'd3) |-> peak_o == PK_W'(PK_MAX));
endmodule

// File: tb/test_flyback_law_map.sv
`timescale 1ns/1ps
module test_flyback_law_map;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  cl_code_i = '0;
  logic        sample_valid_i = 1'b0;
  logic        vo_above_reg_i = 1'b0;
  logic        vo_above_ovs_i = 1'b0;
  logic        ms_tick_i = 1'b0;
  logic [7:0]  peak_o;
  logic [16:0] freq_o;
  logic        cc_o;
  logic [2:0]  region_o;
  logic [16:0] floor_o;

  always #2.5 clk_i = ~clk_i;

  flyback_law_map i_flyback_law_map (
    .clk_i, .rst_ni, .cl_code_i, .sample_valid_i, .vo_above_reg_i,
    .vo_above_ovs_i, .ms_tick_i, .peak_o, .freq_o, .cc_o, .region_o, .floor_o
  );

  typedef struct {
    int pk; int fq; int cc; int rg; int fl; string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // monitor: pops expected items and compares against the ports
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (int'(peak_o) != e.pk || int'(freq_o) != e.fq || int'(cc_o) != e.cc ||
          int'(region_o) != e.rg || int'(floor_o) != e.fl) begin
        failures++;
        $display("FAIL %s: actual pk=%0d fq=%0d cc=%0d rg=%0d fl=%0d expected pk=%0d fq=%0d cc=%0d rg=%0d fl=%0d",
                 e.tag, peak_o, freq_o, cc_o, region_o, floor_o, e.pk, e.fq, e.cc, e.rg, e.fl);
      end
    end
  end

  task automatic expect_out(input string tag, input int pk, input int fq, input int cc,
                            input int rg, input int fl);
    exp_t e;
    repeat (3) @(negedge clk_i);
    e.pk = pk; e.fq = fq; e.cc = cc; e.rg = rg; e.fl = fl; e.tag = tag;
    exp_q.push_back(e);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic set_code(input int c);
    @(negedge clk_i);
    cl_code_i = 10'(c);
  endtask

  task automatic sample(input bit above, input bit ovs);
    @(negedge clk_i);
    sample_valid_i = 1'b1; vo_above_reg_i = above; vo_above_ovs_i = ovs;
    @(negedge clk_i);
    sample_valid_i = 1'b0; vo_above_ovs_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ms_tick_i = 1'b1;
      @(negedge clk_i); ms_tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    expect_out("R1 reset", 0, 0, 0, 0, 1000);
    @(negedge clk_i); rst_ni = 1'b1;

    set_code(0);    expect_out("R3 standby", 63, 1000, 0, 0, 1000);
    set_code(225);  expect_out("R9 equal demand does not arm", 63, 4000, 0, 1, 1000);
    set_code(210);  expect_out("R9 low floor stays low", 63, 2200, 0, 1, 1000);
    set_code(300);  expect_out("R4 light interp and R9 arm", 63, 13000, 0, 1, 4000);
    set_code(399);  expect_out("R2 last light code", 63, 24880, 0, 1, 4000);
    set_code(400);  expect_out("R2 R5 first medium code", 63, 25000, 0, 2, 4000);
    set_code(500);  expect_out("R5 medium interp", 159, 25000, 0, 2, 4000);
    set_code(599);  expect_out("R5 last medium code", 254, 25000, 0, 2, 4000);
    set_code(600);  expect_out("R6 first heavy code", 255, 25000, 0, 3, 4000);
    set_code(790);  expect_out("R6 heavy interp", 255, 55000, 0, 3, 4000);
    set_code(980);  expect_out("R7 top of heavy no cc", 255, 85000, 0, 3, 4000);
    set_code(981);  expect_out("R7 cc entry", 255, 85000, 1, 4, 4000);
    set_code(1023); expect_out("R7 cc full scale", 255, 85000, 1, 4, 4000);

    // timeout release
    set_code(210);  expect_out("R10 R8 hold after drop", 63, 4000, 0, 1, 4000);
    sample(1'b1, 1'b0);
    ticks(499);     expect_out("R12 held at 499 ticks", 63, 4000, 0, 1, 4000);
    ticks(1);       expect_out("R12 release at 500 ticks", 63, 2200, 0, 1, 1000);

    // uncounted ticks and counter clear
    set_code(300);  expect_out("R9 rearm", 63, 13000, 0, 1, 4000);
    set_code(210);  expect_out("R10 hold again", 63, 4000, 0, 1, 4000);
    sample(1'b0, 1'b0);
    ticks(600);     expect_out("R12 ticks below regulation not counted", 63, 4000, 0, 1, 4000);
    sample(1'b1, 1'b0);
    ticks(300);
    sample(1'b0, 1'b0);
    sample(1'b1, 1'b0);
    ticks(499);     expect_out("R13 below sample cleared count", 63, 4000, 0, 1, 4000);
    ticks(1);       expect_out("R13 release after fresh count", 63, 2200, 0, 1, 1000);

    // overshoot release
    set_code(300);  expect_out("R9 rearm for overshoot", 63, 13000, 0, 1, 4000);
    set_code(210);  expect_out("R10 hold before overshoot", 63, 4000, 0, 1, 4000);
    sample(1'b1, 1'b1);
    expect_out("R11 overshoot release", 63, 2200, 0, 1, 1000);

    // demand recovers during hold
    set_code(300);  expect_out("R9 rearm for recovery", 63, 13000, 0, 1, 4000);
    set_code(210);
    sample(1'b1, 1'b0);
    ticks(300);
    set_code(300);  expect_out("R9 hold returns to armed", 63, 13000, 0, 1, 4000);
    set_code(210);
    ticks(499);     expect_out("R9 count cleared on rearm", 63, 4000, 0, 1, 4000);
    ticks(1);       expect_out("R12 release after rearm", 63, 2200, 0, 1, 1000);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule